// File: doc/BRIEF.md
# Receive Descriptor Chain Tracker

This block prepares and follows a singly linked chain of receive buffer descriptors for a streaming ADC capture path. When a start command arrives with a valid configuration, it writes one descriptor per cycle through its descriptor write port. Each descriptor describes one slice of a contiguous capture buffer and points to the descriptor after it. It keeps its own copy of the link fields so that it can walk the chain later.

While capture runs, the DMA engine reports the handle of the descriptor it completed most recently. A consumer polls the block. Each poll returns one of three outcomes. End-of-chain means nothing follows the read cursor. Waiting means the cursor has caught up with the DMA engine. Valid means the cursor moved one step and the response carries the handle of the newly reached descriptor. Only a valid outcome moves the cursor.

Descriptor handles are numbers. Real descriptors use 1 to `MAX_DESC`, where descriptor slot `i` has handle `i+1`. Handle 0 means null. The dummy head entry uses the all-ones handle.

Top module: `rx_desc_chain`

## Requirements
- R1: After reset, `dwr_en_o`, `cfg_err_o` and `rsp_valid_o` are 0. A poll before any start returns end-of-chain, status code 0.
- R2: Every written descriptor has a size field equal to `cfg_eof_num_i * BPC`, where `BPC` is the number of bytes per conversion (default 2).
- R3: Every written descriptor has length 0, its end-of-frame flag at 0 and its owner flag at 1.
- R4: An accepted start writes slots 0 to `cfg_count_i-1`, one per cycle, beginning the cycle after the start. The buffer address starts at `cfg_base_i` and grows by one size per slot. The next field is the next slot's handle (slot+2), except on the last slot, where it is null (0).
- R5: A start is rejected when any of these holds: the base is not a multiple of 4, the size is not a multiple of 4, or the count is 0 or above `MAX_DESC`. A rejected start sets `cfg_err_o`, which stays set until reset. A rejected start writes nothing, and the cursor and chain are left as they were.
- R6: An accepted start moves the read cursor to the dummy head. The head's next entry is handle 1.
- R7: A poll returns end-of-chain (status 0, handle 0) when the cursor's next entry is null.
- R8: Otherwise, a poll returns waiting (status 1, handle 0) when the cursor's handle equals `eof_desc_i`. The cursor does not move.
- R9: Otherwise, the cursor moves to its next entry, and the poll returns valid (status 2) with that entry's handle.
- R10: Each poll is answered with `rsp_valid_o` high for exactly the cycle after the request. `rsp_valid_o` is never high at any other time.
- R11: A poll made during a chain build, or in the same cycle as an accepted start, returns end-of-chain and leaves the cursor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, sampled with the configuration |
| cfg_base_i | input | AW | Byte address of the capture buffer |
| cfg_eof_num_i | input | EW | Conversions per descriptor |
| cfg_count_i | input | CW | Number of descriptors in the chain |
| cfg_err_o | output | 1 | Sticky flag for a rejected configuration |
| dwr_en_o | output | 1 | Descriptor write strobe |
| dwr_idx_o | output | IW | Descriptor slot being written |
| dwr_buf_o | output | AW | Buffer address field |
| dwr_size_o | output | SW | Buffer size field |
| dwr_len_o | output | SW | Length field |
| dwr_eof_o | output | 1 | End-of-frame flag field |
| dwr_owner_o | output | 1 | Owner flag field |
| dwr_next_o | output | HW | Next-descriptor handle field |
| eof_desc_i | input | HW | Handle of the latest descriptor the DMA engine completed |
| poll_i | input | 1 | Poll request |
| rsp_valid_o | output | 1 | Poll response strobe |
| rsp_status_o | output | 2 | 0 end-of-chain, 1 waiting, 2 valid |
| rsp_desc_o | output | HW | Handle returned with a valid response, else 0 |

## Verification
A poll's response is due exactly one cycle after the request. The first descriptor write is due the cycle after an accepted start, with one more write in each following cycle. A rejected configuration shows on the error flag in the cycle after the start. The bench drives inputs just after a rising edge and keeps a behavioural model that updates at the same edges as the design. It compares every output against the model at the falling edge, once every register on the path has settled.

// File: rtl/rx_desc_chain.sv
module rx_desc_chain #(
  parameter int MAX_DESC = 16,
  parameter int AW       = 32,
  parameter int EW       = 12,
  parameter int BPC      = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [AW-1:0]                     cfg_base_i,
  input  logic [EW-1:0]                     cfg_eof_num_i,
  input  logic [$clog2(MAX_DESC+1):0]       cfg_count_i,
  output logic                              cfg_err_o,
  output logic                              dwr_en_o,
  output logic [$clog2(MAX_DESC)-1:0]       dwr_idx_o,
  output logic [AW-1:0]                     dwr_buf_o,
  output logic [EW+$clog2(BPC+1)-1:0]       dwr_size_o,
  output logic [EW+$clog2(BPC+1)-1:0]       dwr_len_o,
  output logic                              dwr_eof_o,
  output logic                              dwr_owner_o,
  output logic [$clog2(MAX_DESC+2)-1:0]     dwr_next_o,
  input  logic [$clog2(MAX_DESC+2)-1:0]     eof_desc_i,
  input  logic                              poll_i,
  output logic                              rsp_valid_o,
  output logic [1:0]                        rsp_status_o,
  output logic [$clog2(MAX_DESC+2)-1:0]     rsp_desc_o
);
  localparam int IW = $clog2(MAX_DESC);
  localparam int HW = $clog2(MAX_DESC+2);
  localparam int CW = $clog2(MAX_DESC+1) + 1;
  localparam int SW = EW + $clog2(BPC+1);
  localparam logic [HW-1:0] HEAD = '1;
  localparam logic [HW-1:0] NUL  = '0;
  localparam logic [1:0] ST_END = 2'd0, ST_WAIT = 2'd1, ST_VALID = 2'd2;

  logic [SW-1:0] cfg_size, size_q;
  logic          well, accept, busy, building, last, err_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [HW-1:0] cur_q, head_next, nx;
  logic [HW-1:0] nxt_mem [MAX_DESC];

  assign cfg_size = SW'(cfg_eof_num_i) * SW'(BPC);
  assign well     = (cfg_base_i[1:0] == 2'b00) && (cfg_size[1:0] == 2'b00) &&
                    (cfg_count_i != '0) && (cfg_count_i <= CW'(MAX_DESC));
  assign accept   = start_i && well;
  assign busy     = building || accept;
  assign last     = (CW'(idx_q) + CW'(1)) == cnt_q;

  assign dwr_en_o    = building;
  assign dwr_idx_o   = idx_q;
  assign dwr_buf_o   = addr_q;
  assign dwr_size_o  = size_q;
  assign dwr_len_o   = '0;
  assign dwr_eof_o   = 1'b0;
  assign dwr_owner_o = 1'b1;
  assign dwr_next_o  = last ? NUL : HW'(idx_q) + HW'(2);
  assign cfg_err_o   = err_q;

  assign head_next = (cnt_q != '0) ? HW'(1) : NUL;
  assign nx        = (cur_q == HEAD) ? head_next : nxt_mem[IW'(cur_q - HW'(1))];

  always_ff @(posedge clk) begin
    if (building) nxt_mem[idx_q] <= dwr_next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      building     <= 1'b0;
      idx_q        <= '0;
      cnt_q        <= '0;
      size_q       <= '0;
      addr_q       <= '0;
      cur_q        <= HEAD;
      err_q        <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_END;
      rsp_desc_o   <= NUL;
    end else begin
      if (start_i && !well) err_q <= 1'b1;

      rsp_valid_o <= poll_i;
      if (poll_i) begin
        rsp_desc_o <= NUL;
        if (busy || nx == NUL)      rsp_status_o <= ST_END;
        else if (cur_q == eof_desc_i) rsp_status_o <= ST_WAIT;
        else begin
          rsp_status_o <= ST_VALID;
          rsp_desc_o   <= nx;
          cur_q        <= nx;
        end
      end

      if (accept) begin
        building <= 1'b1;
        idx_q    <= '0;
        cnt_q    <= cfg_count_i;
        size_q   <= cfg_size;
        addr_q   <= cfg_base_i;
        cur_q    <= HEAD;
      end else if (building) begin
        idx_q  <= idx_q + IW'(1);
        addr_q <= addr_q + AW'(size_q);
        if (last) building <= 1'b0;
      end
    end
  end

  a_r10_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    poll_i |=> rsp_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_i |=> !rsp_valid_o);
  a_r5_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);
  a_r5_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !well) |=> cfg_err_o);
  a_r5_no_build: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !well && !dwr_en_o) |=> !dwr_en_o);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_en_o && !start_i) |=> (!dwr_en_o || dwr_idx_o == '0 ||
      dwr_buf_o == $past(dwr_buf_o) + AW'($past(dwr_size_o))));
  a_r4_null_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_en_o && dwr_next_o == NUL && !start_i) |=> !dwr_en_o);
  a_r9_valid_handle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_status_o == ST_VALID) |-> (rsp_desc_o != NUL && rsp_desc_o != HEAD));
  a_r11_build_end: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && dwr_en_o) |=> (rsp_status_o == ST_END));
endmodule

// File: tb/rx_desc_chain_test.sv
module rx_desc_chain_test;
  localparam int MAXD = 16, AW = 32, EW = 12, BPC = 2;
  localparam int IW = $clog2(MAXD), HW = $clog2(MAXD+2), CW = $clog2(MAXD+1)+1;
  localparam int SW = EW + $clog2(BPC+1);
  localparam int HEADV = (1 << HW) - 1;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, poll_i = 0;
  logic [AW-1:0] cfg_base_i = '0;
  logic [EW-1:0] cfg_eof_num_i = '0;
  logic [CW-1:0] cfg_count_i = '0;
  logic [HW-1:0] eof_desc_i = '0;
  logic cfg_err_o, dwr_en_o, dwr_eof_o, dwr_owner_o, rsp_valid_o;
  logic [IW-1:0] dwr_idx_o;
  logic [AW-1:0] dwr_buf_o;
  logic [SW-1:0] dwr_size_o, dwr_len_o;
  logic [HW-1:0] dwr_next_o, rsp_desc_o;
  logic [1:0] rsp_status_o;

  always #2.5 clk = ~clk;

  rx_desc_chain #(.MAX_DESC(MAXD), .AW(AW), .EW(EW), .BPC(BPC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_base_i(cfg_base_i),
    .cfg_eof_num_i(cfg_eof_num_i), .cfg_count_i(cfg_count_i), .cfg_err_o(cfg_err_o),
    .dwr_en_o(dwr_en_o), .dwr_idx_o(dwr_idx_o), .dwr_buf_o(dwr_buf_o),
    .dwr_size_o(dwr_size_o), .dwr_len_o(dwr_len_o), .dwr_eof_o(dwr_eof_o),
    .dwr_owner_o(dwr_owner_o), .dwr_next_o(dwr_next_o), .eof_desc_i(eof_desc_i),
    .poll_i(poll_i), .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o),
    .rsp_desc_o(rsp_desc_o));

  typedef struct { int idx; longint buf_a; int size; int nxt; } wr_t;
  wr_t wq[$];
  int m_next [1:MAXD];
  int m_cur = HEADV, m_cnt = 0;
  bit m_err = 0, e_rv = 0;
  int e_st = 0, e_desc = 0;
  string e_tag = "R1";
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit busy_before, accept;
      int sz, hn;
      busy_before = wq.size() > 0;
      if (busy_before) void'(wq.pop_front());
      sz = int'(cfg_eof_num_i) * BPC;
      accept = start_i && cfg_base_i[1:0] == 0 && sz % 4 == 0 &&
               cfg_count_i != 0 && int'(cfg_count_i) <= MAXD;
      if (start_i && !accept) m_err = 1;
      e_rv = poll_i;
      if (poll_i) begin
        hn = (m_cur == HEADV) ? (m_cnt > 0 ? 1 : 0) : m_next[m_cur];
        e_desc = 0;
        if (busy_before || accept) begin e_st = 0; e_tag = "R11"; end
        else if (hn == 0) begin e_st = 0; e_tag = "R7"; end
        else if (m_cur == int'(eof_desc_i)) begin e_st = 1; e_tag = "R8"; end
        else begin
          e_st = 2; e_desc = hn;
          e_tag = (m_cur == HEADV) ? "R6" : "R9";
          m_cur = hn;
        end
      end
      if (accept) begin
        wq.delete();
        for (int i = 0; i < int'(cfg_count_i); i++) begin
          wr_t w;
          w.idx = i; w.buf_a = longint'(cfg_base_i) + longint'(i) * sz; w.size = sz;
          w.nxt = (i == int'(cfg_count_i) - 1) ? 0 : i + 2;
          wq.push_back(w);
          m_next[i+1] = w.nxt;
        end
        m_cnt = int'(cfg_count_i);
        m_cur = HEADV;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(dwr_en_o == (wq.size() > 0), "R4 write strobe", dwr_en_o, wq.size() > 0);
      if (wq.size() > 0 && dwr_en_o) begin
        chk(int'(dwr_size_o) == wq[0].size, "R2 size", dwr_size_o, wq[0].size);
        chk(dwr_len_o == 0 && dwr_eof_o == 0 && dwr_owner_o == 1, "R3 len/eof/owner",
            {dwr_len_o, dwr_eof_o, dwr_owner_o}, 1);
        chk(int'(dwr_idx_o) == wq[0].idx, "R4 slot", dwr_idx_o, wq[0].idx);
        chk(longint'(dwr_buf_o) == wq[0].buf_a, "R4 buffer address", dwr_buf_o, wq[0].buf_a);
        chk(int'(dwr_next_o) == wq[0].nxt, "R4 next handle", dwr_next_o, wq[0].nxt);
      end
      chk(cfg_err_o == m_err, "R5 error flag", cfg_err_o, m_err);
      chk(rsp_valid_o == e_rv, "R10 response strobe", rsp_valid_o, e_rv);
      if (e_rv && rsp_valid_o) begin
        chk(int'(rsp_status_o) == e_st, {e_tag, " status"}, rsp_status_o, e_st);
        chk(int'(rsp_desc_o) == e_desc, {e_tag, " handle"}, rsp_desc_o, e_desc);
      end
    end
  end

  task automatic step(bit st, int base, int eofn, int cnt, bit pl, int eofd);
    start_i = st; cfg_base_i = AW'(base); cfg_eof_num_i = EW'(eofn);
    cfg_count_i = CW'(cnt); poll_i = pl; eof_desc_i = HW'(eofd);
    @(posedge clk); #1;
    start_i = 0; poll_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, eof_desc_i);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(dwr_en_o == 0 && cfg_err_o == 0 && rsp_valid_o == 0, "R1 reset outputs",
        {dwr_en_o, cfg_err_o, rsp_valid_o}, 0);
    @(posedge clk); #1;
    step(0, 0, 0, 0, 1, 0);                  // R1 poll before any start
    idle(1);
    step(1, 'h100, 8, 4, 0, 0);              // R2 R4 build of four
    step(0, 0, 0, 0, 1, 0);                  // R11 poll while building
    idle(4);
    step(0, 0, 0, 0, 1, 0);                  // R6 first valid from head
    step(0, 0, 0, 0, 1, 1);                  // R8 waiting on handle 1
    step(0, 0, 0, 0, 1, 3);                  // R9 advance to 2
    step(0, 0, 0, 0, 1, 3);                  // R9 advance to 3
    step(0, 0, 0, 0, 1, 3);                  // R8 wait at 3
    step(0, 0, 0, 0, 1, 0);                  // R9 advance to 4
    step(0, 0, 0, 0, 1, 0);                  // R7 end of chain
    step(0, 0, 0, 0, 1, 4);                  // R7 null has priority over wait
    step(1, 'h200, 6, 3, 1, 0);              // R11 poll with accepted start
    step(1, 'h400, 2, 2, 0, 0);              // R4 restart during build
    idle(3);
    step(0, 0, 0, 0, 1, 0);                  // R6 head again
    step(1, 'h102, 8, 2, 0, 0);              // R5 misaligned base
    idle(2);
    step(0, 0, 0, 0, 1, 0);                  // R5 chain untouched
    step(0, 0, 0, 0, 1, 0);
    step(1, 'h300, 3, 2, 0, 0);              // R5 size not multiple of 4
    step(1, 'h300, 8, 0, 0, 0);              // R5 zero count
    step(1, 'h300, 8, MAXD+1, 0, 0);         // R5 count above limit
    step(1, 'h800, 4, MAXD, 0, 0);           // R4 full-length chain
    idle(MAXD + 1);
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 3, $urandom_range(0, 255) * 4 + (r == 0 ? 2 : 0), $urandom_range(0, 20),
           $urandom_range(0, MAXD+1), $urandom_range(0, 1), $urandom_range(0, MAXD));
    end
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule